// File: doc/BRIEF.md
# Doorbell Sideband Mailbox Bridge

This block lets a host issue one 32-bit register read or write at a time to an agent on a sideband fabric. The host sees four word registers on a small register bus. The address register holds the target address. The data register carries write data out and read data back. The command register packs the routing fields and a go/busy flag. The fourth register is a read-only status word with two sticky error flags.

The host first loads the address, then the data when writing. It then writes the command word with bit 0 set. The block presents a request on a valid/ready channel, waits for a single-beat response and stores any read data. It then clears busy by itself, and the host polls until busy reads 0. A cycle counter aborts a transaction that gets no answer within a programmable limit. While busy is set, host writes have no effect, so the transaction in flight cannot be disturbed.

Top module: `sb_mailbox`

## Requirements
- R1: After reset all four registers read 0, busy is 0 and `sb_req_valid` is 0.
- R2: Word registers are decoded on `hst_addr`: 0x0 command, 0x4 data, 0x8 address, 0xC status. Status bit 0 is the timeout flag and bit 1 the response-error flag. The status word ignores writes, and a write or read with `hst_addr[1:0]` nonzero has no effect or returns 0. When idle, the data and address registers read back what was written.
- R3: Command word fields are device/function in bits 31:24, opcode in 23:16, destination port in 15:8, byte enables in 7:4, BAR select in 3:1 and go/busy in bit 0. A launched request carries these fields along with the address and data registers. Reading the command register returns the stored bits 31:1 and the live busy flag in bit 0.
- R4: A command write with bit 0 = 0 while idle stores the fields and issues no request.
- R5: A command write with bit 0 = 1 while idle launches a transaction. Busy reads 1 from the next cycle. If ready comes after R cycles and the response D cycles after the handshake, busy reads 1 for exactly R+D+2 cycles, counted from the first cycle after the launching write.
- R6: While `sb_req_valid` is 1 and `sb_req_ready` is 0, the request fields stay stable.
- R7: On a response to opcode 6 (read), `sb_rsp_rdata` is written into the data register. A response to any other opcode (7 is write) leaves the data register unchanged.
- R8: While busy is 1, host writes to the command, data and address registers are ignored, and a write with bit 0 set does not start a second request.
- R9: With limit L on `tmo_limit` and R < L, a transaction with R+D > L is aborted. Busy then reads 1 for exactly L+2 cycles, status bit 0 is set and the data register is unchanged.
- R10: A response that arrives with R+D = L, in the same cycle the limit is reached, completes normally and does not set the timeout flag.
- R11: A response with `sb_rsp_err` = 1 sets status bit 1. Both status flags stay set until the next launch, which clears them.
- R12: If ready does not come within L+1 cycles of the launch, `sb_req_valid` drops with no handshake, status bit 0 is set and busy clears after L+2 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_sel | input | 1 | Host write strobe qualifier |
| hst_wr | input | 1 | Host write enable |
| hst_addr | input | 4 | Host byte offset |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Register read data, combinational on `hst_addr` |
| tmo_limit | input | TMO_W | Timeout limit in cycles; held stable while busy |
| sb_req_valid | output | 1 | Request valid |
| sb_req_ready | input | 1 | Request accepted by fabric |
| sb_req_devfn | output | 8 | Target device/function |
| sb_req_opcode | output | 8 | Opcode |
| sb_req_port | output | 8 | Destination port |
| sb_req_be | output | 4 | Byte enables |
| sb_req_bar | output | 3 | BAR select |
| sb_req_addr | output | 32 | Target register address |
| sb_req_wdata | output | 32 | Write data |
| sb_rsp_valid | input | 1 | Response valid, single cycle |
| sb_rsp_err | input | 1 | Response error status |
| sb_rsp_rdata | input | 32 | Response read data |

## Verification
The two events that can fall in the same cycle are a response being accepted and the timeout counter reaching its limit. The response has priority. To provoke the clash, the bench sweeps the responder's ready delay R and response delay D over a small limit L, so that R+D = L lands exactly on the limit cycle. Each case is judged arithmetically: the number of busy cycles polled must be R+D+2, status bit 0 must stay clear and the read data must land in the data register. Cases one cycle later must show L+2 busy cycles, the timeout flag set and the data register unchanged.

// File: rtl/sbmb_pkg.sv
// Shared constants and types for the doorbell sideband mailbox.
// Assumes the command fields plus the go bit fill one host word exactly.
package sbmb_pkg;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned HOST_AW = 4;
    localparam int unsigned FN_W    = 8;
    localparam int unsigned OP_W    = 8;
    localparam int unsigned PORT_W  = 8;
    localparam int unsigned BE_W    = 4;
    localparam int unsigned BAR_W   = 3;

    localparam logic [OP_W-1:0] OP_RD = 8'd6;
    localparam logic [OP_W-1:0] OP_WR = 8'd7;

    localparam logic [1:0] SEL_CMD  = 2'd0;
    localparam logic [1:0] SEL_DATA = 2'd1;
    localparam logic [1:0] SEL_ADDR = 2'd2;
    localparam logic [1:0] SEL_STAT = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_REQ      = 2'd1,
        ST_WAIT_RSP = 2'd2,
        ST_DONE     = 2'd3
    } sbmb_state_e;

    typedef struct packed {
        logic [FN_W-1:0]   devfn;
        logic [OP_W-1:0]   opcode;
        logic [PORT_W-1:0] port;
        logic [BE_W-1:0]   be;
        logic [BAR_W-1:0]  bar;
    } sbmb_cmd_t;
endpackage

// File: rtl/sbmb_regs.sv
// Host register file: command, data, address and read-only status words.
// Assumes busy comes from the controller; every write is dropped while busy.
// The go bit turns a command write into a one-cycle launch pulse.
module sbmb_regs
    import sbmb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hst_sel,
    input  logic              hst_wr,
    input  logic [HOST_AW-1:0] hst_addr,
    input  logic [WORD_W-1:0] hst_wdata,
    output logic [WORD_W-1:0] hst_rdata,
    input  logic              busy,
    input  logic              cap_en,
    input  logic [WORD_W-1:0] cap_data,
    input  logic              tmo_flag,
    input  logic              err_flag,
    output logic              launch,
    output sbmb_cmd_t         cmd_q,
    output logic [WORD_W-1:0] addr_q,
    output logic [WORD_W-1:0] data_q
);
    logic       aligned;
    logic       wr_ok;
    logic [1:0] widx;

    // Word decode and the write gate shared by all registers
    always_comb begin
        aligned = (hst_addr[1:0] == 2'b00);
        widx    = hst_addr[3:2];
        wr_ok   = hst_sel && hst_wr && aligned && !busy;
        launch  = wr_ok && (widx == SEL_CMD) && hst_wdata[0];
    end

    // Register updates from host writes and read-data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            if (wr_ok && widx == SEL_CMD)  cmd_q  <= hst_wdata[WORD_W-1:1];
            if (wr_ok && widx == SEL_ADDR) addr_q <= hst_wdata;
            if (cap_en)                    data_q <= cap_data;
            else if (wr_ok && widx == SEL_DATA) data_q <= hst_wdata;
        end
    end

    // Read multiplexer
    always_comb begin
        hst_rdata = '0;
        if (aligned) begin
            case (widx)
                SEL_CMD:  hst_rdata = {cmd_q, busy};
                SEL_DATA: hst_rdata = data_q;
                SEL_ADDR: hst_rdata = addr_q;
                SEL_STAT: hst_rdata = {{(WORD_W-2){1'b0}}, err_flag, tmo_flag};
                default:  hst_rdata = '0;
            endcase
        end
    end

    a_r8_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && hst_sel && hst_wr) |=> $stable(addr_q));
    a_r8_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && hst_sel && hst_wr) |=> $stable(cmd_q));
    a_r8_data_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && hst_sel && hst_wr && !cap_en) |=> $stable(data_q));
endmodule

// File: rtl/sbmb_ctrl.sv
// Transaction controller: IDLE -> REQ -> WAIT_RSP -> DONE -> IDLE.
// Assumes tmo_limit is held stable while busy. A response wins over a timeout
// in the same cycle, and a handshake in REQ wins over a timeout as well.
module sbmb_ctrl
    import sbmb_pkg::*;
#(
    parameter int unsigned TMO_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [OP_W-1:0]   cmd_opcode,
    input  logic [TMO_W-1:0]  tmo_limit,
    input  logic              req_ready,
    input  logic              rsp_valid,
    input  logic              rsp_err,
    input  logic [WORD_W-1:0] rsp_rdata,
    output logic              busy,
    output logic              req_valid,
    output logic              cap_en,
    output logic [WORD_W-1:0] cap_data,
    output logic              tmo_flag,
    output logic              err_flag
);
    localparam int unsigned CNT_W = TMO_W + 1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    sbmb_state_e      st_q;
    logic [CNT_W-1:0] cnt_q;
    logic             limit_hit;

    // Derived outputs and the timeout compare
    always_comb begin
        limit_hit = (cnt_q >= {1'b0, tmo_limit});
        busy      = (st_q != ST_IDLE);
        req_valid = (st_q == ST_REQ);
        cap_en    = (st_q == ST_WAIT_RSP) && rsp_valid && (cmd_opcode == OP_RD);
        cap_data  = rsp_rdata;
    end

    // State, cycle counter and sticky flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            cnt_q    <= '0;
            tmo_flag <= 1'b0;
            err_flag <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (launch) begin
                        st_q     <= ST_REQ;
                        cnt_q    <= '0;
                        tmo_flag <= 1'b0;
                        err_flag <= 1'b0;
                    end
                end
                ST_REQ: begin
                    if (req_ready) begin
                        st_q  <= ST_WAIT_RSP;
                        cnt_q <= cnt_q + CNT_ONE;
                    end else if (limit_hit) begin
                        st_q     <= ST_DONE;
                        tmo_flag <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + CNT_ONE;
                    end
                end
                ST_WAIT_RSP: begin
                    if (rsp_valid) begin
                        st_q     <= ST_DONE;
                        err_flag <= rsp_err;
                    end else if (limit_hit) begin
                        st_q     <= ST_DONE;
                        tmo_flag <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + CNT_ONE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    a_r5_busy_after_launch: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> busy);
    a_r9_wait_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT_RSP && !rsp_valid && limit_hit) |=> (st_q == ST_DONE && tmo_flag));
    a_r10_rsp_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT_RSP && rsp_valid) |=> (st_q == ST_DONE && !tmo_flag));
    a_r12_req_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && limit_hit) |=> (!req_valid && tmo_flag));
endmodule

// File: rtl/sb_mailbox.sv
// Doorbell sideband mailbox top: joins the host register file to the
// transaction controller and routes the stored command to the request channel.
// Assumes one outstanding transaction and a single-beat response.
module sb_mailbox
    import sbmb_pkg::*;
#(
    parameter int unsigned TMO_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hst_sel,
    input  logic              hst_wr,
    input  logic [3:0]        hst_addr,
    input  logic [31:0]       hst_wdata,
    output logic [31:0]       hst_rdata,
    input  logic [TMO_W-1:0]  tmo_limit,
    output logic              sb_req_valid,
    input  logic              sb_req_ready,
    output logic [7:0]        sb_req_devfn,
    output logic [7:0]        sb_req_opcode,
    output logic [7:0]        sb_req_port,
    output logic [3:0]        sb_req_be,
    output logic [2:0]        sb_req_bar,
    output logic [31:0]       sb_req_addr,
    output logic [31:0]       sb_req_wdata,
    input  logic              sb_rsp_valid,
    input  logic              sb_rsp_err,
    input  logic [31:0]       sb_rsp_rdata
);
    sbmb_cmd_t         cmd_q;
    logic [WORD_W-1:0] addr_q;
    logic [WORD_W-1:0] data_q;
    logic              launch;
    logic              busy;
    logic              cap_en;
    logic [WORD_W-1:0] cap_data;
    logic              tmo_flag;
    logic              err_flag;

    sbmb_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .hst_sel  (hst_sel),
        .hst_wr   (hst_wr),
        .hst_addr (hst_addr),
        .hst_wdata(hst_wdata),
        .hst_rdata(hst_rdata),
        .busy     (busy),
        .cap_en   (cap_en),
        .cap_data (cap_data),
        .tmo_flag (tmo_flag),
        .err_flag (err_flag),
        .launch   (launch),
        .cmd_q    (cmd_q),
        .addr_q   (addr_q),
        .data_q   (data_q)
    );

    sbmb_ctrl #(.TMO_W(TMO_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .cmd_opcode(cmd_q.opcode),
        .tmo_limit (tmo_limit),
        .req_ready (sb_req_ready),
        .rsp_valid (sb_rsp_valid),
        .rsp_err   (sb_rsp_err),
        .rsp_rdata (sb_rsp_rdata),
        .busy      (busy),
        .req_valid (sb_req_valid),
        .cap_en    (cap_en),
        .cap_data  (cap_data),
        .tmo_flag  (tmo_flag),
        .err_flag  (err_flag)
    );

    // Request fields come straight from the frozen host registers
    always_comb begin
        sb_req_devfn  = cmd_q.devfn;
        sb_req_opcode = cmd_q.opcode;
        sb_req_port   = cmd_q.port;
        sb_req_be     = cmd_q.be;
        sb_req_bar    = cmd_q.bar;
        sb_req_addr   = addr_q;
        sb_req_wdata  = data_q;
    end

    a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_req_valid && !sb_req_ready) |=> ($stable(sb_req_addr) && $stable(sb_req_opcode)
            && $stable(sb_req_wdata) && $stable(sb_req_port)));
endmodule

// File: tb/sim_sb_mailbox.sv
module sim_sb_mailbox;
    localparam int CLK_PERIOD = 10;
    localparam int TMO_W = 16;
    localparam int LIM = 6;
    localparam logic [3:0] O_CMD = 4'h0, O_DATA = 4'h4, O_ADDR = 4'h8, O_STAT = 4'hC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hst_sel = 1'b0, hst_wr = 1'b0;
    logic [3:0] hst_addr = 4'h0;
    logic [31:0] hst_wdata = '0, hst_rdata;
    logic [TMO_W-1:0] tmo_limit = TMO_W'(LIM);
    logic sb_req_valid, sb_req_ready = 1'b0;
    logic [7:0] sb_req_devfn, sb_req_opcode, sb_req_port;
    logic [3:0] sb_req_be;
    logic [2:0] sb_req_bar;
    logic [31:0] sb_req_addr, sb_req_wdata;
    logic sb_rsp_valid = 1'b0, sb_rsp_err = 1'b0;
    logic [31:0] sb_rsp_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sb_mailbox #(.TMO_W(TMO_W)) u0 (
        .clk(clk), .rst_n(rst_n), .hst_sel(hst_sel), .hst_wr(hst_wr),
        .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .tmo_limit(tmo_limit), .sb_req_valid(sb_req_valid), .sb_req_ready(sb_req_ready),
        .sb_req_devfn(sb_req_devfn), .sb_req_opcode(sb_req_opcode), .sb_req_port(sb_req_port),
        .sb_req_be(sb_req_be), .sb_req_bar(sb_req_bar), .sb_req_addr(sb_req_addr),
        .sb_req_wdata(sb_req_wdata), .sb_rsp_valid(sb_rsp_valid), .sb_rsp_err(sb_rsp_err),
        .sb_rsp_rdata(sb_rsp_rdata)
    );

    int n_run = 0, n_fail = 0;

    // Responder model state
    int rdy_delay = 0, rsp_delay = 1;
    int rq_cnt = 0, dcnt = 0, hs_count = 0, hold_bad = 0;
    bit pend = 0, seen = 0;
    logic [31:0] rmem [16];
    logic [31:0] exp_mem [16];
    logic [7:0] c_op, c_port, c_devfn;
    logic [3:0] c_be;
    logic [2:0] c_bar;
    logic [31:0] c_addr, c_wdata;

    function automatic logic [31:0] seed_val(int i);
        return 32'hC0DE0000 + 32'(i) * 32'h00010111;
    endfunction

    // Responder: ready after rdy_delay, response rsp_delay cycles after handshake
    always @(negedge clk) begin
        sb_rsp_valid = 1'b0;
        sb_rsp_err   = 1'b0;
        if (!rst_n) begin
            sb_req_ready = 1'b0; pend = 0; seen = 0; rq_cnt = 0;
        end else begin
            if (sb_req_ready) begin
                sb_req_ready = 1'b0; pend = 1; dcnt = 1; hs_count++;
                seen = 0; rq_cnt = 0;
                if (c_op == 8'd7 && c_port == 8'h04) rmem[c_addr[3:0]] = c_wdata;
            end else if (sb_req_valid && !pend) begin
                if (!seen) begin
                    seen = 1;
                    c_op = sb_req_opcode; c_port = sb_req_port; c_devfn = sb_req_devfn;
                    c_be = sb_req_be; c_bar = sb_req_bar; c_addr = sb_req_addr; c_wdata = sb_req_wdata;
                end else if (c_op !== sb_req_opcode || c_addr !== sb_req_addr ||
                             c_wdata !== sb_req_wdata || c_port !== sb_req_port) begin
                    hold_bad++;
                end
                if (rq_cnt == rdy_delay) sb_req_ready = 1'b1;
                else rq_cnt++;
            end else begin
                seen = 0; rq_cnt = 0;
            end
            if (pend) begin
                if (dcnt == rsp_delay) begin
                    sb_rsp_valid = 1'b1;
                    sb_rsp_err   = (c_port != 8'h04);
                    sb_rsp_rdata = rmem[c_addr[3:0]];
                    pend = 0;
                end else dcnt++;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        hst_sel = 1'b1; hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
        @(negedge clk);
        hst_sel = 1'b0; hst_wr = 1'b0;
    endtask

    task automatic hread(input logic [3:0] a, output logic [31:0] v);
        hst_addr = a;
        #1;
        v = hst_rdata;
    endtask

    // Poll busy from the first cycle after the launching write
    task automatic poll(output int nb);
        logic [31:0] v;
        nb = 0;
        forever begin
            hread(O_CMD, v);
            if (!v[0] || nb >= 200) break;
            nb++;
            @(negedge clk);
        end
    endtask

    task automatic launch(input logic [7:0] op, input logic [7:0] port, input logic [7:0] fn,
                          input logic [3:0] be, input logic [2:0] bar, input int rdl,
                          input int rsd, output int nb);
        rdy_delay = rdl; rsp_delay = rsd;
        hwrite(O_CMD, {fn, op, port, be, bar, 1'b1});
        poll(nb);
        repeat (10) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        int nb, hs0;
        for (int i = 0; i < 16; i++) begin rmem[i] = seed_val(i); exp_mem[i] = seed_val(i); end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int i = 0; i < 4; i++) begin
            hread(4'(i * 4), v);
            chk("R1 register after reset", v, 32'h0);
        end
        chk("R1 req_valid after reset", {31'b0, sb_req_valid}, 32'h0);

        // R2 readback, status write ignored, misaligned ignored
        hwrite(O_ADDR, 32'h12345678);
        hread(O_ADDR, v); chk("R2 address readback", v, 32'h12345678);
        hwrite(O_DATA, 32'hA5A55A5A);
        hread(O_DATA, v); chk("R2 data readback", v, 32'hA5A55A5A);
        hwrite(O_STAT, 32'hFFFFFFFF);
        hread(O_STAT, v); chk("R2 status ignores write", v, 32'h0);
        hwrite(4'h9, 32'h0BADF00D);
        hread(O_ADDR, v); chk("R2 misaligned write ignored", v, 32'h12345678);
        hread(4'h5, v); chk("R2 misaligned read zero", v, 32'h0);

        // R4 fields only
        hs0 = hs_count;
        hwrite(O_CMD, {8'h9A, 8'd6, 8'h04, 4'h5, 3'h6, 1'b0});
        repeat (5) @(negedge clk);
        chk("R4 no handshake", 32'(hs_count - hs0), 32'h0);
        hread(O_CMD, v); chk("R4 command stored, busy 0", v, {8'h9A, 8'd6, 8'h04, 4'h5, 3'h6, 1'b0});

        // R3 field routing on a read
        hwrite(O_ADDR, 32'h3);
        launch(8'd6, 8'h04, 8'h9A, 4'h5, 3'h6, 0, 1, nb);
        chk("R3 devfn", {24'b0, c_devfn}, 32'h9A);
        chk("R3 opcode", {24'b0, c_op}, 32'h6);
        chk("R3 be", {28'b0, c_be}, 32'h5);
        chk("R3 bar", {29'b0, c_bar}, 32'h6);
        chk("R3 addr", c_addr, 32'h3);
        chk("R5 busy cycles R0 D1", 32'(nb), 32'd3);
        hread(O_DATA, v); chk("R7 read data captured", v, exp_mem[3]);

        // R5 R7 R9 R10 R12 sweep over ready and response delays
        for (int r = 0; r <= 3; r++) begin
            for (int d = 1; d <= 8; d++) begin
                int rr;
                bit ok;
                logic [3:0] a;
                logic [31:0] mark;
                rr = (r == 3) ? LIM + 1 : r;
                if (rr > LIM && d > 1) continue;
                a = 4'((r * 8 + d) % 16);
                mark = 32'hDEAD0000 + 32'(r * 16 + d);
                ok = (rr < LIM) && (rr + d <= LIM);
                hwrite(O_ADDR, {28'b0, a});
                hwrite(O_DATA, mark);
                hs0 = hs_count;
                launch(8'd6, 8'h04, 8'h10, 4'hF, 3'h0, rr, d, nb);
                if (rr > LIM) begin
                    chk("R12 busy cycles", 32'(nb), 32'(LIM + 2));
                    chk("R12 no handshake", 32'(hs_count - hs0), 32'h0);
                    hread(O_STAT, v); chk("R12 timeout flag", v, 32'h1);
                    hread(O_DATA, v); chk("R12 data unchanged", v, mark);
                end else if (rr + d == LIM) begin
                    chk("R10 busy cycles", 32'(nb), 32'(rr + d + 2));
                    hread(O_STAT, v); chk("R10 no timeout", v, 32'h0);
                    hread(O_DATA, v); chk("R10 data captured", v, exp_mem[a]);
                end else if (ok) begin
                    chk("R5 busy cycles", 32'(nb), 32'(rr + d + 2));
                    hread(O_STAT, v); chk("R5 status clear", v, 32'h0);
                    hread(O_DATA, v); chk("R7 data captured", v, exp_mem[a]);
                    chk("R3 request address", c_addr, {28'b0, a});
                end else begin
                    chk("R9 busy cycles", 32'(nb), 32'(LIM + 2));
                    hread(O_STAT, v); chk("R9 timeout flag", v, 32'h1);
                    hread(O_DATA, v); chk("R9 data unchanged", v, mark);
                end
            end
        end

        // R7 writes leave data register alone, then read back through the agent
        for (int i = 0; i < 4; i++) begin
            logic [31:0] wd;
            wd = 32'h5000_0000 + 32'(i) * 32'h0101_0101;
            hwrite(O_ADDR, 32'(8 + i));
            hwrite(O_DATA, wd);
            launch(8'd7, 8'h04, 8'h10, 4'hF, 3'h0, 1, 2, nb);
            exp_mem[8 + i] = wd;
            chk("R3 write data carried", c_wdata, wd);
            hread(O_DATA, v); chk("R7 write leaves data", v, wd);
        end
        for (int i = 0; i < 4; i++) begin
            hwrite(O_ADDR, 32'(8 + i));
            launch(8'd6, 8'h04, 8'h10, 4'hF, 3'h0, 0, 2, nb);
            hread(O_DATA, v); chk("R7 readback after write", v, exp_mem[8 + i]);
        end

        // R8 writes while busy are ignored
        hwrite(O_ADDR, 32'h5);
        hwrite(O_DATA, 32'h77778888);
        hs0 = hs_count;
        rdy_delay = 2; rsp_delay = 3;
        hwrite(O_CMD, {8'h10, 8'd7, 8'h04, 4'hF, 3'h0, 1'b1});
        hwrite(O_ADDR, 32'hE);
        hwrite(O_DATA, 32'h11112222);
        hwrite(O_CMD, {8'h44, 8'd6, 8'h04, 4'h1, 3'h1, 1'b1});
        poll(nb);
        repeat (10) @(negedge clk);
        exp_mem[5] = 32'h77778888;
        hread(O_ADDR, v); chk("R8 address kept", v, 32'h5);
        hread(O_DATA, v); chk("R8 data kept", v, 32'h77778888);
        hread(O_CMD, v); chk("R8 command kept", v, {8'h10, 8'd7, 8'h04, 4'hF, 3'h0, 1'b0});
        chk("R8 single handshake", 32'(hs_count - hs0), 32'h1);
        chk("R6 fields stable while waiting", 32'(hold_bad), 32'h0);

        // R11 error flag sticky until next launch
        hwrite(O_ADDR, 32'h2);
        launch(8'd6, 8'h05, 8'h10, 4'hF, 3'h0, 0, 1, nb);
        hread(O_STAT, v); chk("R11 error flag set", v, 32'h2);
        repeat (5) @(negedge clk);
        hread(O_STAT, v); chk("R11 error flag sticky", v, 32'h2);
        launch(8'd6, 8'h04, 8'h10, 4'hF, 3'h0, 0, 1, nb);
        hread(O_STAT, v); chk("R11 flags cleared by launch", v, 32'h0);
        hread(O_DATA, v); chk("R7 data after clear", v, exp_mem[2]);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule